// File: doc/BRIEF.md
# Peak-Current PWM Pulse Generator

This block is the digital pulse engine of a peak-current-mode switching controller. A period timer, whose length is swept by a triangular jitter sequence around a programmable nominal value, marks the start of each switching period. At that point the gate output is switched on unless the block is disabled or in burst skipping. Afterwards the gate can only go low. This happens when a comparator flag reports that the sensed current has reached its limit, or when the duty ceiling is reached. Comparator flags are ignored during a fixed leading-edge blanking window at the start of every pulse.

Three sources end a pulse. The first is an absolute current-limit flag. The second is a feedback-derived peak flag. The third applies only during soft start: a digital comparison of the sensed-current code against one quarter of the soft-start code. Two feedback-level flags drive a hysteretic burst mode. A low flag enters burst mode, and while it is active whole periods are skipped. A high flag leaves burst mode. All comparators, ramp compensation and gate clamping are outside this block.

Top module: `pwm_pulse_gen`

## Requirements
- R1: While reset is asserted, `gate` and `pulse_active` are both 0.
- R2: On the first clock edge after reset is released, and at every later period boundary, `gate` and `pulse_active` go to 1 if `en` is 1 and burst mode is off. `pulse_active` then stays 1 until the next period boundary, even after `gate` has been cleared.
- R3: In the on-time count, cycle 0 is the first cycle with `gate` high. During cycles 0 to BLANK_CYC-1 (default 35), all three termination sources are ignored. A termination source seen during cycle k, with k at least BLANK_CYC, makes `gate` low from cycle k+1, so the pulse is k+1 cycles wide.
- R4: If no termination source fires, a pulse in a period of P cycles is exactly floor(P*47/100) cycles wide.
- R5: While `ilim_trip` is 1, the pulse ends per R3, whatever the feedback and soft-start inputs are.
- R6: A pulse ends per R3 when `fb_trip` is 1. Once `gate` has been cleared, it stays low for the rest of that period.
- R7: While `ss_run` is 1, the pulse ends per R3 when `cs_code` > floor(`ss_code`/4). While `ss_run` is 0, `cs_code` and `ss_code` have no effect.
- R8: With nominal period N, let S = floor(N*6/100). The k-th period after reset (k = 0, 1, ...) lasts N - S + floor(S*t_k/4) cycles. The sequence t_k runs 0,1,...,8,7,...,1,0,1,... and t_0 = 0.
- R9: A cycle with `fb_low`=1 and `fb_high`=0 turns burst mode on. A cycle with `fb_high`=1 turns it off. Otherwise burst mode holds its state. Burst mode is sampled only at period boundaries, and a period that begins in burst mode has `gate` and `pulse_active` both 0.
- R10: When `en` is 0 during a cycle, `gate` and `pulse_active` are 0 from the next cycle on. A pulse in progress is cut short, and no pulse starts until a period boundary at which `en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Block enable |
| per_nom | input | PER_W (16) | Nominal period in clock cycles |
| ilim_trip | input | 1 | Absolute current-limit comparator flag |
| fb_trip | input | 1 | Feedback peak-setpoint comparator flag |
| ss_run | input | 1 | Soft start in progress |
| ss_code | input | CODE_W (8) | Digitised soft-start level |
| cs_code | input | CODE_W (8) | Digitised sensed current |
| fb_low | input | 1 | Feedback below lower burst threshold |
| fb_high | input | 1 | Feedback above upper burst threshold |
| gate | output | 1 | Gate drive |
| pulse_active | output | 1 | Current period carries a pulse |

## Verification
The bench first runs the block with no termination flags, so that each pulse is limited only by the duty ceiling. It then times ten consecutive periods, which distinguishes the triangular jitter sweep from a fixed period and tests the width computed per period. A constantly asserted current-limit flag gives pulses exactly one cycle longer than the blanking window, which shows that blanking masks the flag and then releases it. A feedback flag raised mid-pulse checks cut-off timing and that the gate is not set again within the period. Soft-start codes just above and exactly at the quarter threshold, together with a large code while soft start is inactive, separate a strict comparison from a non-strict one. Single-cycle burst flags check entry, hold and exit of the skip mode, and a mid-pulse disable checks truncation.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Integer percentage of a value, rounded down.
  function automatic logic [31:0] pct_of(input logic [31:0] val, input int unsigned pct);
    return (val * 32'(pct)) / 32'd100;
  endfunction
endpackage

// File: rtl/pwm_jitter.sv
module pwm_jitter #(
  parameter int PER_W     = 16,
  parameter int JIT_PCT   = 6,
  parameter int JIT_STEPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] per_nom,
  output logic [PER_W-1:0] per_next
);
  import pwm_pkg::*;
  localparam int TRI_MAX = 2 * JIT_STEPS;
  localparam int TRI_W   = $clog2(TRI_MAX + 1);

  logic [TRI_W-1:0] tri_q;
  logic             up_q;
  logic [31:0]      span, offs, per32;

  always_comb begin
    span     = pct_of(32'(per_nom), JIT_PCT);
    offs     = (span * 32'(tri_q)) / 32'(JIT_STEPS);
    per32    = 32'(per_nom) - span + offs;
    per_next = per32[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      if (up_q) begin
        tri_q <= tri_q + 1'b1;
        if (32'(tri_q) + 1 == TRI_MAX) up_q <= 1'b0;
      end else begin
        tri_q <= tri_q - 1'b1;
        if (32'(tri_q) == 1) up_q <= 1'b1;
      end
    end
  end

  p_tri_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tri_q) <= TRI_MAX);
  p_tri_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (32'(tri_q) == 32'($past(tri_q)) + 1) || (32'(tri_q) + 1 == 32'($past(tri_q))));
  p_tri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tri_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per_next,
  output logic             tick,
  output logic [PER_W-1:0] cnt
);
  logic             start_q;
  logic [PER_W-1:0] cur_per_q;
  logic [PER_W-1:0] cnt_q;

  assign tick = start_q || (cnt_q == cur_per_q - 1'b1);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b1;
      cur_per_q <= '0;
      cnt_q     <= '0;
    end else begin
      start_q <= 1'b0;
      if (tick) begin
        cnt_q     <= '0;
        cur_per_q <= per_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_in_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> cnt_q < cur_per_q);
  p_start_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
endmodule

// File: rtl/pwm_burst.sv
module pwm_burst (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_low,
  input  logic fb_high,
  output logic burst
);
  logic burst_q;
  assign burst = burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              burst_q <= 1'b0;
    else if (fb_high)        burst_q <= 1'b0;
    else if (fb_low)         burst_q <= 1'b1;
  end

  p_burst_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_low && !fb_high) |=> burst_q);
  p_burst_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_high |=> !burst_q);
  p_burst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_low && !fb_high) |=> $stable(burst_q));
endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int PER_W     = 16,
  parameter int CODE_W    = 8,
  parameter int BLANK_CYC = 35,
  parameter int DUTY_PCT  = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              burst,
  input  logic [PER_W-1:0]  cnt,
  input  logic [PER_W-1:0]  per_next,
  input  logic              ilim_trip,
  input  logic              fb_trip,
  input  logic              ss_run,
  input  logic [CODE_W-1:0] ss_code,
  input  logic [CODE_W-1:0] cs_code,
  output logic              gate,
  output logic              pulse_active
);
  import pwm_pkg::*;

  logic             gate_q, act_q;
  logic [PER_W:0]   max_on_q;
  logic [31:0]      max_on_next;
  logic             blanked, ss_hit, flag_hit, duty_hit, term;

  always_comb begin
    max_on_next = pct_of(32'(per_next), DUTY_PCT);
    blanked     = 32'(cnt) < BLANK_CYC;
    ss_hit      = ss_run && (cs_code > (ss_code >> 2));
    flag_hit    = !blanked && (ilim_trip || fb_trip || ss_hit);
    duty_hit    = ({1'b0, cnt} + 1'b1) >= max_on_q;
    term        = flag_hit || duty_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      act_q    <= 1'b0;
      max_on_q <= '0;
    end else begin
      if (tick) max_on_q <= max_on_next[PER_W:0];
      if (!en) begin
        gate_q <= 1'b0;
        act_q  <= 1'b0;
      end else if (tick) begin
        gate_q <= !burst;
        act_q  <= !burst;
      end else if (gate_q && term) begin
        gate_q <= 1'b0;
      end
    end
  end

  assign gate         = gate_q;
  assign pulse_active = act_q;

  p_rise_at_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !tick) |=> !gate_q);
  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && blanked && en && !tick && !duty_hit) |=> gate_q);
  p_duty_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> ({1'b0, cnt} < max_on_q));
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_q && !act_q));
  p_active_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> act_q);
  p_burst_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && burst) |=> (!gate_q && !act_q));
endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen #(
  parameter int PER_W     = 16,
  parameter int CODE_W    = 8,
  parameter int BLANK_CYC = 35,
  parameter int DUTY_PCT  = 47,
  parameter int JIT_PCT   = 6,
  parameter int JIT_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PER_W-1:0]  per_nom,
  input  logic              ilim_trip,
  input  logic              fb_trip,
  input  logic              ss_run,
  input  logic [CODE_W-1:0] ss_code,
  input  logic [CODE_W-1:0] cs_code,
  input  logic              fb_low,
  input  logic              fb_high,
  output logic              gate,
  output logic              pulse_active
);
  logic             tick, burst;
  logic [PER_W-1:0] cnt, per_next;

  pwm_jitter #(.PER_W(PER_W), .JIT_PCT(JIT_PCT), .JIT_STEPS(JIT_STEPS)) u_jit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .per_nom(per_nom), .per_next(per_next)
  );

  pwm_timebase #(.PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_next(per_next), .tick(tick), .cnt(cnt)
  );

  pwm_burst u_burst (
    .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .fb_high(fb_high), .burst(burst)
  );

  pwm_gate_ctl #(.PER_W(PER_W), .CODE_W(CODE_W), .BLANK_CYC(BLANK_CYC),
                 .DUTY_PCT(DUTY_PCT)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .burst(burst), .cnt(cnt),
    .per_next(per_next), .ilim_trip(ilim_trip), .fb_trip(fb_trip), .ss_run(ss_run),
    .ss_code(ss_code), .cs_code(cs_code), .gate(gate), .pulse_active(pulse_active)
  );
endmodule

// File: tb/sim_pwm_pulse_gen.sv
module sim_pwm_pulse_gen;
  localparam int CLK_PER = 10;
  localparam int NOM     = 200;
  localparam int BLANK   = 35;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [15:0] per_nom = 16'(NOM);
  logic       ilim_trip = 1'b0, fb_trip = 1'b0, ss_run = 1'b0;
  logic [7:0] ss_code = 8'd0, cs_code = 8'd0;
  logic       fb_low = 1'b0, fb_high = 1'b0;
  logic       gate, pulse_active;

  int checks = 0;
  int fails  = 0;
  int rise_t[0:15];
  int len_t[0:15];

  always #(CLK_PER/2) clk = ~clk;

  pwm_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .per_nom(per_nom), .ilim_trip(ilim_trip),
    .fb_trip(fb_trip), .ss_run(ss_run), .ss_code(ss_code), .cs_code(cs_code),
    .fb_low(fb_low), .fb_high(fb_high), .gate(gate), .pulse_active(pulse_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_per(input int k);
    int t = (k % 16 <= 8) ? (k % 16) : (16 - k % 16);
    int s = NOM * 6 / 100;
    return NOM - s + (s * t) / 4;
  endfunction

  function automatic int exp_width(input int k);
    return exp_per(k) * 47 / 100;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1; ilim_trip = 1'b0; fb_trip = 1'b0; ss_run = 1'b0;
    ss_code = 8'd0; cs_code = 8'd0; fb_low = 1'b0; fb_high = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Record rise time and width of the first n pulses after reset release.
  task automatic run_pulses(input int n);
    int t = 0;
    int k = 0;
    bit prev = 1'b0;
    while (k < n && t < 5000) begin
      @(negedge clk);
      t++;
      if (gate && !prev) rise_t[k] = t;
      if (!gate && prev) begin len_t[k] = t - rise_t[k]; k++; end
      prev = gate;
    end
  endtask

  task automatic wait_rise(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!gate && cyc < 1000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(gate == 1'b0, "R1 gate in reset", int'(gate), 0);
    chk(pulse_active == 1'b0, "R1 pulse_active in reset", int'(pulse_active), 0);
  endtask

  task automatic t_free_run();
    do_reset();
    run_pulses(10);
    chk(rise_t[0] == 1, "R2 first pulse after reset", rise_t[0], 1);
    for (int k = 0; k < 10; k++)
      chk(len_t[k] == exp_width(k), "R4 duty ceiling width", len_t[k], exp_width(k));
    for (int k = 0; k < 9; k++)
      chk(rise_t[k+1] - rise_t[k] == exp_per(k), "R8 jittered period",
          rise_t[k+1] - rise_t[k], exp_per(k));
  endtask

  task automatic t_ilim();
    do_reset();
    ilim_trip = 1'b1; fb_trip = 1'b0;
    run_pulses(2);
    chk(len_t[0] == BLANK + 1, "R3 R5 blanked ilim width", len_t[0], BLANK + 1);
    chk(len_t[1] == BLANK + 1, "R5 ilim second pulse", len_t[1], BLANK + 1);
    ilim_trip = 1'b0;
  endtask

  task automatic t_fb();
    int c;
    bit bad = 1'b0;
    bit act_ok = 1'b1;
    do_reset();
    wait_rise(c);
    for (int i = 1; i <= 60; i++) @(negedge clk);
    chk(gate == 1'b1, "R6 gate before fb_trip", int'(gate), 1);
    fb_trip = 1'b1;
    @(negedge clk);
    chk(gate == 1'b0, "R3 R6 fb_trip ends pulse at 61", int'(gate), 0);
    fb_trip = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (gate) bad = 1'b1;
      if (!pulse_active) act_ok = 1'b0;
    end
    chk(!bad, "R6 no re-set in same period", int'(bad), 0);
    chk(act_ok, "R2 pulse_active held to period end", int'(act_ok), 1);
  endtask

  task automatic t_softstart();
    do_reset();
    ss_run = 1'b1; ss_code = 8'd200; cs_code = 8'd51;
    run_pulses(1);
    chk(len_t[0] == BLANK + 1, "R7 cs above quarter ends pulse", len_t[0], BLANK + 1);
    do_reset();
    ss_run = 1'b1; ss_code = 8'd200; cs_code = 8'd50;
    run_pulses(1);
    chk(len_t[0] == exp_width(0), "R7 cs at quarter no trip", len_t[0], exp_width(0));
    do_reset();
    ss_run = 1'b0; ss_code = 8'd0; cs_code = 8'd255;
    run_pulses(1);
    chk(len_t[0] == exp_width(0), "R7 codes ignored outside soft start", len_t[0], exp_width(0));
  endtask

  task automatic t_burst();
    int c;
    bit bad = 1'b0;
    do_reset();
    wait_rise(c);
    repeat (10) @(negedge clk);
    fb_low = 1'b1;
    @(negedge clk);
    fb_low = 1'b0;
    chk(gate == 1'b1, "R9 burst entry waits for boundary", int'(gate), 1);
    repeat (200) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (gate || pulse_active) bad = 1'b1;
    end
    chk(!bad, "R9 periods skipped in burst", int'(bad), 0);
    fb_high = 1'b1;
    @(negedge clk);
    fb_high = 1'b0;
    wait_rise(c);
    chk(gate == 1'b1 && c <= 230, "R9 burst exit resumes pulses", c, 230);
  endtask

  task automatic t_enable();
    int c;
    bit bad = 1'b0;
    do_reset();
    wait_rise(c);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0, "R10 gate truncated", int'(gate), 0);
    chk(pulse_active == 1'b0, "R10 pulse_active cleared", int'(pulse_active), 0);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (gate) bad = 1'b1;
    end
    chk(!bad, "R10 no pulse while disabled", int'(bad), 0);
    en = 1'b1;
    wait_rise(c);
    chk(gate == 1'b1 && c <= 230, "R10 R2 pulse after re-enable", c, 230);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_ilim();
    t_fb();
    t_softstart();
    t_burst();
    t_enable();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule